// File: doc/BRIEF.md
# Packed Integer Matrix Multiply-Accumulate Unit

This block computes a small integer matrix product with an optional addend: each result row is the sum of a 32-bit addend row and the product of one row of the left operand with an 8-column right operand. Operand elements are 2, 4 or 8 bits wide, signed or unsigned, and are packed into 32-bit words. The left and right operands each carry their own precision code. How many elements share a word, and so the inner length K, follows at run time from the wider of the two element widths.

Software, or an upstream engine, first writes the three operand register files through a plain write port. It then issues one command word over a valid/ready channel. The command carries the row count (1 to 8), the fixed depth of 8, both precision codes and an addend-enable flag. The unit streams the result out one row per beat, eight 32-bit columns wide, on a second valid/ready channel. Back-pressure follows the usual rules. A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high. While `res_valid` is high and `res_ready` is low, the row data and row index are held and no further row is computed. A row is consumed on the edge where both signals are high.

Top module: `dpa_unit`

## Requirements
- R1: `cmd_ready` is high exactly when the unit is idle, and a command is taken on an edge where `cmd_valid` and `cmd_ready` are both high. The command word holds the row count in bits 31:24, the depth in bits 23:16, the left-operand code in bits 15:8 and the right-operand code in bits 7:0.
- R2: The precision codes are 3 = unsigned 2-bit, 4 = signed 2-bit, 5 = unsigned 4-bit, 6 = signed 4-bit, 7 = unsigned 8-bit and 8 = signed 8-bit. An even code means signed.
- R3: A command is rejected if either code lies outside 3..8, if the depth field differs from 8, or if the row count lies outside 1..8. On rejection, `err` is high for the single cycle after acceptance. No result beat and no `done` follow, and `cmd_ready` stays high.
- R4: If either operand is 8-bit, a word holds four 8-bit slots, so K = 32. Otherwise it holds eight 4-bit slots, so K = 64. Slot j of word s carries inner index s*slots+j. A narrower element sits in the low bits of its slot and is extended according to its own code.
- R5: The write port selects the operand with `ld_sel`: 0 = left, 1 = right, 2 = addend. Value 3 writes nothing. The left word for row r and step s is at r*8+s. The right word for step s and column n is at s*8+n. The addend for row r and column n is at r*8+n.
- R6: Each result column equals the addend, plus the sum over K of the left element times the right element, wrapped modulo 2^32. When `cmd_acc` is low, the addend is taken as zero.
- R7: The unit emits one beat per row, for rows 0 to count-1 in order. `res_row` carries the row index, and column n appears at `res_data[32n+31:32n]`. A beat is held unchanged while `res_ready` is low, and `res_valid` drops for at least one cycle after each accepted beat.
- R8: `done` is high for exactly one cycle, right after the edge that accepts the last row, and the unit is then idle.
- R9: Writes are ignored while `cmd_ready` is low. A write made on the same edge that accepts a command is used by that command.
- R10: After reset, `cmd_ready` is 1, and `res_valid`, `done` and `err` are 0. All operand words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_info | input | 32 | Packed command word: row count, depth, left code, right code |
| cmd_acc | input | 1 | Add the addend rows when high |
| ld_en | input | 1 | Operand write strobe |
| ld_sel | input | 2 | Target file: 0 left, 1 right, 2 addend, 3 none |
| ld_addr | input | 6 | Word address within the selected file |
| ld_data | input | 32 | Word to write |
| res_valid | output | 1 | Result row offered |
| res_ready | input | 1 | Downstream takes the row |
| res_row | output | 3 | Index of the offered row |
| res_data | output | 256 | Eight 32-bit result columns |
| done | output | 1 | One-cycle pulse after the last row is taken |
| err | output | 1 | One-cycle pulse after a rejected command |

## Verification
Operand writes and command acceptance can land on the same clock edge. The bench provokes this by raising `ld_en` together with `cmd_valid` while the unit is idle, and then requires the streamed rows to reflect the new word. The bench also writes an operand while the unit is busy, and requires that the current rows and the rows of a later command both match a model that never saw that write. A stalled result beat overlapping the unit's internal row sequencing is judged by holding `res_ready` low for several cycles and requiring the beat to stay unchanged.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    EW2 = 2'd0,
    EW4 = 2'd1,
    EW8 = 2'd2
  } elem_w_e;

  typedef struct packed {
    elem_w_e w;
    logic    sgn;
  } prec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_MAC  = 2'd2,
    ST_OUT  = 2'd3
  } state_e;

  localparam logic [7:0] CODE_MIN = 8'd3;
  localparam logic [7:0] CODE_MAX = 8'd8;

  function automatic logic code_ok(input logic [7:0] c);
    return (c >= CODE_MIN) && (c <= CODE_MAX);
  endfunction

  // even codes are signed; pairs (3,4) (5,6) (7,8) share a width
  function automatic prec_t code_prec(input logic [7:0] c);
    prec_t p;
    p.sgn = ~c[0];
    case (c)
      8'd3, 8'd4: p.w = EW2;
      8'd5, 8'd6: p.w = EW4;
      default:    p.w = EW8;
    endcase
    return p;
  endfunction

  // take the element from the low bits of a slot and extend to 9 bits
  function automatic logic signed [8:0] elem_ext(input logic [7:0] s, input prec_t p);
    logic x;
    logic signed [8:0] v;
    case (p.w)
      EW2: begin
        x = p.sgn & s[1];
        v = {{7{x}}, s[1:0]};
      end
      EW4: begin
        x = p.sgn & s[3];
        v = {{5{x}}, s[3:0]};
      end
      default: begin
        x = p.sgn & s[7];
        v = {x, s};
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dpa_decode.sv
module dpa_decode
  import dpa_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int MAX_ROWS = 8,
  localparam int RCW     = $clog2(MAX_ROWS + 1)
) (
  input  logic [31:0]    info,
  output logic           ok,
  output logic [RCW-1:0] rows,
  output prec_t          a_p,
  output prec_t          b_p,
  output logic           wide
);

  logic [7:0] f_rpt, f_dep, f_a, f_b;

  assign {f_rpt, f_dep, f_a, f_b} = info;

  assign ok = code_ok(f_a) && code_ok(f_b)
           && (f_dep == 8'(DEPTH))
           && (f_rpt != 8'd0) && (f_rpt <= 8'(MAX_ROWS));

  assign rows = RCW'(f_rpt);
  assign a_p  = code_prec(f_a);
  assign b_p  = code_prec(f_b);
  // the wider element sets the slot size for both operands
  assign wide = (a_p.w == EW8) || (b_p.w == EW8);

endmodule

// File: rtl/dpa_regfile.sv
module dpa_regfile #(
  parameter int WORDS = 64,
  parameter int DW    = 32,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r*DW +: DW] = mem[raddr[r*AW +: AW]];
  end

endmodule

// File: rtl/dpa_lane.sv
module dpa_lane
  import dpa_pkg::*;
#(
  parameter int DW     = 32,
  localparam int NSLOT = DW / 4
) (
  input  logic [DW-1:0] a_word,
  input  logic [DW-1:0] b_word,
  input  logic          wide,
  input  prec_t         a_p,
  input  prec_t         b_p,
  output logic [DW-1:0] dot
);

  logic signed [17:0] prod [NSLOT];

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    logic [7:0] wa, wb, sa, sb;
    if (2 * j < NSLOT) begin : g_lo
      assign wa = a_word[8*j +: 8];
      assign wb = b_word[8*j +: 8];
    end else begin : g_hi
      assign wa = '0;
      assign wb = '0;
    end
    assign sa = wide ? wa : {4'b0000, a_word[4*j +: 4]};
    assign sb = wide ? wb : {4'b0000, b_word[4*j +: 4]};
    assign prod[j] = elem_ext(sa, a_p) * elem_ext(sb, b_p);
  end

  always_comb begin
    dot = '0;
    for (int j = 0; j < NSLOT; j++) dot = dot + DW'(prod[j]);
  end

endmodule

// File: rtl/dpa_unit.sv
module dpa_unit
  import dpa_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int DEPTH     = 8,
  parameter int MAX_ROWS  = 8,
  parameter int DW        = 32,
  localparam int A_WORDS  = MAX_ROWS * DEPTH,
  localparam int B_WORDS  = DEPTH * LANES,
  localparam int C_WORDS  = MAX_ROWS * LANES,
  localparam int AB_MAX   = (A_WORDS > B_WORDS) ? A_WORDS : B_WORDS,
  localparam int ALL_MAX  = (AB_MAX > C_WORDS) ? AB_MAX : C_WORDS,
  localparam int LD_AW    = $clog2(ALL_MAX),
  localparam int ROW_W    = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [31:0]         cmd_info,
  input  logic                cmd_acc,
  input  logic                ld_en,
  input  logic [1:0]          ld_sel,
  input  logic [LD_AW-1:0]    ld_addr,
  input  logic [DW-1:0]       ld_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [ROW_W-1:0]    res_row,
  output logic [LANES*DW-1:0] res_data,
  output logic                done,
  output logic                err
);

  localparam int A_AW   = $clog2(A_WORDS);
  localparam int B_AW   = $clog2(B_WORDS);
  localparam int C_AW   = $clog2(C_WORDS);
  localparam int STEP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RCW    = $clog2(MAX_ROWS + 1);

  state_e                     state_q;
  logic [ROW_W-1:0]           row_q, last_q;
  logic [STEP_W-1:0]          step_q;
  logic                       acc_en_q, wide_q, done_q, err_q;
  prec_t                      a_p_q, b_p_q;
  logic [LANES-1:0][DW-1:0]   acc_q;

  logic                       idle;
  logic                       dec_ok, dec_wide;
  logic [RCW-1:0]             dec_rows;
  prec_t                      dec_a, dec_b;

  assign idle = (state_q == ST_IDLE);

  dpa_decode #(.DEPTH(DEPTH), .MAX_ROWS(MAX_ROWS)) u_dec (
    .info (cmd_info),
    .ok   (dec_ok),
    .rows (dec_rows),
    .a_p  (dec_a),
    .b_p  (dec_b),
    .wide (dec_wide)
  );

  // operand files: writes land only while idle
  logic                  a_we, b_we, c_we;
  logic [A_AW-1:0]       a_ra;
  logic [DW-1:0]         a_rd;
  logic [LANES*B_AW-1:0] b_ra;
  logic [LANES*DW-1:0]   b_rd;
  logic [LANES*C_AW-1:0] c_ra;
  logic [LANES*DW-1:0]   c_rd;

  assign a_we = ld_en && idle && (ld_sel == 2'd0);
  assign b_we = ld_en && idle && (ld_sel == 2'd1);
  assign c_we = ld_en && idle && (ld_sel == 2'd2);
  assign a_ra = A_AW'(int'(row_q) * DEPTH + int'(step_q));

  dpa_regfile #(.WORDS(A_WORDS), .DW(DW), .NRD(1)) u_afile (
    .clk, .rst_n, .we(a_we), .waddr(ld_addr[A_AW-1:0]), .wdata(ld_data),
    .raddr(a_ra), .rdata(a_rd)
  );

  dpa_regfile #(.WORDS(B_WORDS), .DW(DW), .NRD(LANES)) u_bfile (
    .clk, .rst_n, .we(b_we), .waddr(ld_addr[B_AW-1:0]), .wdata(ld_data),
    .raddr(b_ra), .rdata(b_rd)
  );

  dpa_regfile #(.WORDS(C_WORDS), .DW(DW), .NRD(LANES)) u_cfile (
    .clk, .rst_n, .we(c_we), .waddr(ld_addr[C_AW-1:0]), .wdata(ld_data),
    .raddr(c_ra), .rdata(c_rd)
  );

  // column lanes
  logic [DW-1:0] dot [LANES];

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign b_ra[n*B_AW +: B_AW] = B_AW'(int'(step_q) * LANES + n);
    assign c_ra[n*C_AW +: C_AW] = C_AW'(int'(row_q) * LANES + n);

    dpa_lane #(.DW(DW)) u_lane (
      .a_word (a_rd),
      .b_word (b_rd[n*DW +: DW]),
      .wide   (wide_q),
      .a_p    (a_p_q),
      .b_p    (b_p_q),
      .dot    (dot[n])
    );
  end

  // sequencer: init row, DEPTH multiply-add steps, present row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      row_q    <= '0;
      last_q   <= '0;
      step_q   <= '0;
      acc_en_q <= 1'b0;
      wide_q   <= 1'b0;
      a_p_q    <= '0;
      b_p_q    <= '0;
      acc_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (dec_ok) begin
              a_p_q    <= dec_a;
              b_p_q    <= dec_b;
              wide_q   <= dec_wide;
              acc_en_q <= cmd_acc;
              last_q   <= ROW_W'(dec_rows - 1'b1);
              row_q    <= '0;
              state_q  <= ST_INIT;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_INIT: begin
          for (int n = 0; n < LANES; n++)
            acc_q[n] <= acc_en_q ? c_rd[n*DW +: DW] : '0;
          step_q  <= '0;
          state_q <= ST_MAC;
        end
        ST_MAC: begin
          for (int n = 0; n < LANES; n++) acc_q[n] <= acc_q[n] + dot[n];
          step_q <= step_q + 1'b1;
          if (step_q == STEP_W'(DEPTH - 1)) state_q <= ST_OUT;
        end
        default: begin
          if (res_ready) begin
            if (row_q == last_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              row_q   <= row_q + 1'b1;
              state_q <= ST_INIT;
            end
          end
        end
      endcase
    end
  end

  assign cmd_ready = idle;
  assign res_valid = (state_q == ST_OUT);
  assign res_row   = row_q;
  assign res_data  = acc_q;
  assign done      = done_q;
  assign err       = err_q;

  // R1: the unit only leaves idle after a command was offered
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_ready) |-> $past(cmd_valid));

  // R3: a rejection follows an accepted command and starts nothing
  p_err_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && cmd_ready));

  p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cmd_ready && !res_valid && !done));

  // R7: a stalled beat is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_row)));

  // R7: an accepted beat is not repeated on the next cycle
  p_beat_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid);

  // R8: done follows the final handshake and leaves the unit idle
  p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(res_valid && res_ready) && cmd_ready));

endmodule

// File: tb/dpa_unit_tb_top.sv
`timescale 1ns/1ps
module dpa_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, cmd_acc, ld_en, res_ready;
  logic         cmd_ready, res_valid, done, err;
  logic [31:0]  cmd_info, ld_data;
  logic [1:0]   ld_sel;
  logic [5:0]   ld_addr;
  logic [2:0]   res_row;
  logic [255:0] res_data;

  int nchecks = 0;
  int nerrs   = 0;
  int cyc     = 0;

  bit [31:0] ma [64];
  bit [31:0] mb [64];
  bit [31:0] mc [64];

  always #4 clk = ~clk;

  dpa_unit dut_i (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_info, .cmd_acc,
    .ld_en, .ld_sel, .ld_addr, .ld_data,
    .res_valid, .res_ready, .res_row, .res_data, .done, .err
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nerrs++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int cw(int c);
    return (c <= 4) ? 2 : (c <= 6) ? 4 : 8;
  endfunction

  function automatic int elem(bit [31:0] w, int sh, int bits, bit sg);
    int v = int'((w >> sh) & ((32'd1 << bits) - 1));
    if (sg && v >= (1 << (bits - 1))) v = v - (1 << bits);
    return v;
  endfunction

  function automatic logic [255:0] exp_row(int r, int ac, int bc, bit acc);
    int wa  = cw(ac);
    int wb  = cw(bc);
    int opc = (wa == 8 || wb == 8) ? 4 : 8;
    int sw  = 32 / opc;
    logic [255:0] row = '0;
    for (int n = 0; n < 8; n++) begin
      bit [31:0] s = acc ? mc[r*8+n] : 32'd0;
      for (int k = 0; k < 8 * opc; k++) begin
        int ea = elem(ma[r*8 + k/opc], (k % opc) * sw, wa, (ac % 2) == 0);
        int eb = elem(mb[(k/opc)*8 + n], (k % opc) * sw, wb, (bc % 2) == 0);
        s = s + 32'(ea * eb);
      end
      row[n*32 +: 32] = s;
    end
    return row;
  endfunction

  function automatic void model_write(int sel, int a, bit [31:0] v);
    case (sel)
      0: ma[a] = v;
      1: mb[a] = v;
      2: mc[a] = v;
      default: ;
    endcase
  endfunction

  // ---------------- drivers ----------------
  task automatic load(input int sel, input int a, input bit [31:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 2'(sel); ld_addr = 6'(a); ld_data = v;
    model_write(sel, a, v);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic fill(input int sel, input bit rnd, input bit [31:0] v);
    for (int a = 0; a < 64; a++) load(sel, a, rnd ? $urandom : v);
  endtask

  // side: 0 none, 1 write on the accepting edge, 2 write while busy
  task automatic run_cmd(input string name, input int rpt, input int ac, input int bc,
                         input bit acc, input int stall, input int side,
                         input int ls, input int la, input bit [31:0] lv);
    logic [255:0] snap;
    @(negedge clk);
    check("R1", {name, " ready when idle"}, cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_info  = {8'(rpt), 8'd8, 8'(ac), 8'(bc)};
    cmd_acc   = acc;
    if (side == 1) begin
      ld_en = 1'b1; ld_sel = 2'(ls); ld_addr = 6'(la); ld_data = lv;
      model_write(ls, la, lv);  // R9: same-edge write is used
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    ld_en     = 1'b0;
    check("R1", {name, " busy after accept"}, cmd_ready, 0);
    if (side == 2) begin
      ld_en = 1'b1; ld_sel = 2'(ls); ld_addr = 6'(la); ld_data = lv;  // R9: must be ignored
      @(negedge clk);
      ld_en = 1'b0;
    end
    for (int r = 0; r < rpt; r++) begin
      int t = 0;
      while (!res_valid && t < 100) begin
        @(negedge clk);
        t++;
      end
      check("R6", {name, " row data"}, res_data, exp_row(r, ac, bc, acc));
      check("R7", {name, " row index"}, res_row, r);
      if (stall > 0) begin
        snap = res_data;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          check("R7", {name, " held under stall"}, {res_valid, res_data}, {1'b1, snap});
        end
      end
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      if (r < rpt - 1) check("R7", {name, " gap after beat"}, res_valid, 0);
    end
    check("R8", {name, " done after last row"}, {done, cmd_ready}, 2'b11);
    @(negedge clk);
    check("R8", {name, " done is one cycle"}, done, 0);
  endtask

  task automatic bad_cmd(input string name, input int rpt, input int dep,
                         input int ac, input int bc);
    bit seen = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_info  = {8'(rpt), 8'(dep), 8'(ac), 8'(bc)};
    cmd_acc   = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R3", {name, " err pulse and still ready"}, {err, cmd_ready}, 2'b11);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (res_valid || done || err || !cmd_ready) seen = 1'b1;
    end
    check("R3", {name, " no beat, no done"}, seen, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R10", "reset outputs", {cmd_ready, res_valid, done, err}, 4'b1000);
    run_cmd("reset_zero", 2, 8, 8, 1'b1, 0, 0, 0, 0, 0);  // R10: files read zero
  endtask

  task automatic t_s8_extreme();
    fill(0, 0, 32'h80808080);
    fill(1, 0, 32'h80808080);
    fill(2, 1, 0);
    run_cmd("s8_min", 3, 8, 8, 1'b1, 0, 0, 0, 0, 0);  // R4 R6
  endtask

  task automatic t_u8_wrap();
    fill(0, 0, 32'hFFFFFFFF);
    fill(1, 0, 32'hFFFFFFFF);
    fill(2, 0, 32'hFFFF0000);
    run_cmd("u8_wrap", 1, 7, 7, 1'b1, 0, 0, 0, 0, 0);  // R6 modulo wrap
    run_cmd("u8_by_s8", 2, 7, 8, 1'b1, 0, 0, 0, 0, 0); // R2 per-operand sign
  endtask

  task automatic t_s4_noacc();
    fill(0, 0, 32'h88888888);
    fill(1, 0, 32'h88888888);
    fill(2, 1, 0);
    run_cmd("s4_min_noacc", 8, 6, 6, 1'b0, 0, 0, 0, 0, 0);  // R6 addend off, R4 K=64
  endtask

  task automatic t_mixed();
    fill(0, 1, 0);
    fill(1, 1, 0);
    fill(2, 1, 0);
    run_cmd("u2_by_s8", 4, 3, 8, 1'b1, 0, 0, 0, 0, 0);  // R4 narrow in wide slot
    run_cmd("s4_by_s2", 5, 6, 4, 1'b1, 0, 0, 0, 0, 0);  // R4 narrow slots
    run_cmd("s2_by_u4", 2, 4, 5, 1'b0, 0, 0, 0, 0, 0);  // R2
  endtask

  task automatic t_backpressure();
    run_cmd("stall", 3, 5, 8, 1'b1, 3, 0, 0, 0, 0);  // R7
  endtask

  task automatic t_invalid();
    bad_cmd("code9", 2, 8, 9, 8);
    bad_cmd("code0", 2, 8, 8, 0);
    bad_cmd("code2", 2, 8, 2, 6);
    bad_cmd("rows0", 0, 8, 7, 7);
    bad_cmd("rows9", 9, 8, 7, 7);
    bad_cmd("depth4", 2, 4, 7, 7);
  endtask

  task automatic t_load_races();
    run_cmd("same_edge_load", 1, 8, 8, 1'b1, 0, 1, 0, 0, 32'h7F7F7F7F);  // R9
    run_cmd("busy_load", 2, 8, 8, 1'b1, 0, 2, 0, 1, 32'h12345678);      // R9
    run_cmd("after_busy", 1, 8, 8, 1'b1, 0, 0, 0, 0, 0);                // R9
    load(3, 0, 32'hDEADBEEF);                                           // R5: select 3 writes nothing
    run_cmd("sel3_ignored", 1, 8, 7, 1'b1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_addr_map();
    fill(0, 1, 0);
    fill(1, 1, 0);
    fill(2, 1, 0);
    load(1, 63, 32'h01020304);  // R5: last step, last column
    load(2, 7, 32'h55555555);   // R5: row 0, column 7
    run_cmd("addr_map", 8, 7, 5, 1'b1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 8; i++) begin
      int ac = 3 + ($urandom % 6);
      int bc = 3 + ($urandom % 6);
      int rp = 1 + ($urandom % 8);
      fill(0, 1, 0);
      fill(1, 1, 0);
      fill(2, 1, 0);
      run_cmd("random", rp, ac, bc, 1'($urandom), i % 3, 0, 0, 0, 0);  // R6
    end
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_acc = 1'b0; cmd_info = '0;
    ld_en = 1'b0; ld_sel = '0; ld_addr = '0; ld_data = '0; res_ready = 1'b0;
    for (int i = 0; i < 64; i++) begin
      ma[i] = 0; mb[i] = 0; mc[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_s8_extreme();
    t_u8_wrap();
    t_s4_noacc();
    t_mixed();
    t_backpressure();
    t_invalid();
    t_load_races();
    t_addr_map();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

endmodule